// File: doc/BRIEF.md
# Byte-Sequenced Non-Volatile Memory Access Controller

This block lets a host reach an external byte-wide non-volatile memory through one 32-bit control/status register. Each host write to the register carries a 3-bit command in bits 31:29 and a byte in bits 23:16. Two commands load the 16-bit memory address one byte at a time. Two more use the loaded address to start a write cycle or a read cycle on the memory port.

While a write or read cycle runs, bit 31 of the register reads as 1. The host polls this bit until it reads 0 before it issues the next command. When a read cycle ends, the fetched byte appears in bits 23:16 of the register. The memory side is a plain parallel port: a 16-bit address, write data, read data, and active-high write and read strobes. Its timing is fixed by the parameters `WRITE_CYCLES` (default 8) and `READ_CYCLES` (default 4).

Top module: `nvbyte_ctrl`

## Requirements
- R1: On a host write, the command is taken from bits 31:29 of `reg_wdata` and the byte from bits 23:16. All other written bits have no effect.
- R2: Command 3'b100 stores the byte as the low address byte, and command 3'b101 stores it as the high address byte. `mem_addr` always shows {high byte, low byte}.
- R3: Command 3'b110 stores the byte as the data byte, drives it on `mem_wdata`, and raises busy for exactly `WRITE_CYCLES` clocks, starting with the clock after the accepting edge.
- R4: Command 3'b111 raises busy for exactly `READ_CYCLES` clocks, starting with the clock after the accepting edge.
- R5: A command whose bit 31 is 0 (3'b0xx) changes no address or data byte and starts no memory cycle. While idle, neither strobe is asserted.
- R6: Address-load commands complete in the accepting clock and never raise busy.
- R7: In a write cycle whose clocks are numbered 0 to `WRITE_CYCLES`-1, `mem_we` is high exactly on clocks `WRITE_CYCLES`/4 through `WRITE_CYCLES`/4+`WRITE_CYCLES`/2-1 (integer division). `mem_we` and `mem_re` are never high together.
- R8: `mem_re` is high on every clock of a read cycle. `mem_rdata` is sampled on the last clock, and bits 23:16 of `reg_rdata` then hold the fetched byte. Outside a completed read, they hold the last byte written with 3'b110.
- R9: Bit 31 of `reg_rdata` is 1 exactly while a write or read cycle is in progress, and 0 otherwise.
- R10: A command that arrives while busy is ignored. The address bytes, the data byte and the cycle in progress are left unchanged.
- R11: After reset, both address bytes and the data byte are zero, busy is 0, and both strobes are low.
- R12: Bits 30:24 and 15:0 of `reg_rdata` always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe for the control/status register |
| reg_wdata | input | 32 | Host write data (command 31:29, byte 23:16) |
| reg_rdata | output | 32 | Register read value (busy 31, byte 23:16) |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_we | output | 1 | Write strobe, active high |
| mem_re | output | 1 | Read strobe, active high |

## Verification
The assertions assume that `mem_rdata` is settled on the clock where the read cycle ends. They also assume that the host may write at any time, including while busy, so the ignore rule is checked by a property and not left to host discipline. The stimulus uses a memory model that answers combinationally from the current address. It drives every input on the falling clock edge. It deliberately issues commands in the middle of a busy cycle, inactive commands, and writes with junk in the unused register bits, so that the assertions and the reference model both meet those cases.

// File: rtl/nvbyte_pkg.sv
package nvbyte_pkg;

  localparam logic [2:0] CMD_LD_LO = 3'b100;
  localparam logic [2:0] CMD_LD_HI = 3'b101;
  localparam logic [2:0] CMD_WRITE = 3'b110;
  localparam logic [2:0] CMD_READ  = 3'b111;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_LD_LO,
    ACT_LD_HI,
    ACT_WRITE,
    ACT_READ
  } act_e;

  // Map a 3-bit command code onto an internal action.
  function automatic act_e cmd_to_act(logic [2:0] code);
    act_e a;
    case (code)
      CMD_LD_LO: a = ACT_LD_LO;
      CMD_LD_HI: a = ACT_LD_HI;
      CMD_WRITE: a = ACT_WRITE;
      CMD_READ:  a = ACT_READ;
      default:   a = ACT_NONE;
    endcase
    return a;
  endfunction

  // First clock of the write strobe inside a cycle of 'total' clocks.
  function automatic int unsigned we_first(int unsigned total);
    return total / 4;
  endfunction

  // True while clock 'idx' of a write cycle lies in the middle half.
  function automatic logic we_window(int unsigned idx, int unsigned total);
    return (idx >= we_first(total)) && (idx < we_first(total) + total / 2);
  endfunction

endpackage

// File: rtl/nvbyte_cmd_dec.sv
module nvbyte_cmd_dec
  import nvbyte_pkg::*;
(
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        busy,
  output act_e        act,
  output logic [7:0]  byte_in,
  output logic        accept,
  output logic        accept_addr,
  output logic        start_mem
);

  localparam int CMD_MSB  = 31;
  localparam int CMD_LSB  = 29;
  localparam int BYTE_MSB = 23;
  localparam int BYTE_LSB = 16;

  logic [2:0] code;

  always_comb begin
    code    = reg_wdata[CMD_MSB:CMD_LSB];
    byte_in = reg_wdata[BYTE_MSB:BYTE_LSB];
    act     = cmd_to_act(code);
  end

  assign accept      = reg_wr && !busy && (act != ACT_NONE);
  assign accept_addr = accept && ((act == ACT_LD_LO) || (act == ACT_LD_HI));
  assign start_mem   = accept && ((act == ACT_WRITE) || (act == ACT_READ));

endmodule

// File: rtl/nvbyte_seq.sv
module nvbyte_seq
  import nvbyte_pkg::*;
#(
  parameter int WRITE_CYCLES = 8,
  parameter int READ_CYCLES  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_mem,
  input  act_e act,
  output logic busy,
  output logic rd_op,
  output logic [$clog2((WRITE_CYCLES > READ_CYCLES ? WRITE_CYCLES : READ_CYCLES) + 1)-1:0] cnt,
  output logic done,
  output logic rd_sample
);

  localparam int MAXC  = (WRITE_CYCLES > READ_CYCLES) ? WRITE_CYCLES : READ_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WRITE_CYCLES - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(READ_CYCLES - 1);

  logic [CNT_W-1:0] last_idx;

  assign last_idx  = rd_op ? RD_LAST : WR_LAST;
  assign done      = busy && (cnt == last_idx);
  assign rd_sample = done && rd_op;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      rd_op <= 1'b0;
      cnt   <= '0;
    end else if (start_mem) begin
      busy  <= 1'b1;
      rd_op <= (act == ACT_READ);
      cnt   <= '0;
    end else if (done) begin
      busy  <= 1'b0;
      cnt   <= '0;
    end else if (busy) begin
      cnt   <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/nvbyte_regs.sv
module nvbyte_regs
  import nvbyte_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  act_e       act,
  input  logic [7:0] byte_in,
  input  logic       rd_sample,
  input  logic [7:0] mem_rdata,
  output logic [7:0] addr_lo,
  output logic [7:0] addr_hi,
  output logic [7:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo <= '0;
      addr_hi <= '0;
      data    <= '0;
    end else if (accept) begin
      case (act)
        ACT_LD_LO: addr_lo <= byte_in;
        ACT_LD_HI: addr_hi <= byte_in;
        ACT_WRITE: data    <= byte_in;
        default:   ;
      endcase
    end else if (rd_sample) begin
      data <= mem_rdata;
    end
  end

endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
  import nvbyte_pkg::*;
#(
  parameter int WRITE_CYCLES = 8,
  parameter int READ_CYCLES  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        mem_we,
  output logic        mem_re
);

  localparam int MAXC  = (WRITE_CYCLES > READ_CYCLES) ? WRITE_CYCLES : READ_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  act_e             act;
  logic [7:0]       byte_in;
  logic             accept;
  logic             accept_addr;
  logic             start_mem;
  logic             busy;
  logic             rd_op;
  logic [CNT_W-1:0] cnt;
  logic             done;
  logic             rd_sample;
  logic [7:0]       addr_lo;
  logic [7:0]       addr_hi;
  logic [7:0]       data;

  nvbyte_cmd_dec u_dec (
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .busy        (busy),
    .act         (act),
    .byte_in     (byte_in),
    .accept      (accept),
    .accept_addr (accept_addr),
    .start_mem   (start_mem)
  );

  nvbyte_seq #(
    .WRITE_CYCLES (WRITE_CYCLES),
    .READ_CYCLES  (READ_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_mem (start_mem),
    .act       (act),
    .busy      (busy),
    .rd_op     (rd_op),
    .cnt       (cnt),
    .done      (done),
    .rd_sample (rd_sample)
  );

  nvbyte_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .act       (act),
    .byte_in   (byte_in),
    .rd_sample (rd_sample),
    .mem_rdata (mem_rdata),
    .addr_lo   (addr_lo),
    .addr_hi   (addr_hi),
    .data      (data)
  );

  // Memory port: address and data are driven straight from the registers.
  assign mem_addr  = {addr_hi, addr_lo};
  assign mem_wdata = data;
  assign mem_re    = busy && rd_op;
  assign mem_we    = busy && !rd_op && we_window(32'(cnt), WRITE_CYCLES);

  assign reg_rdata = {busy, 7'b0, data, 16'b0};

endmodule

// File: rtl/nvbyte_ctrl_chk.sv
module nvbyte_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] reg_rdata,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic [7:0]  mem_rdata,
  input logic        mem_we,
  input logic        mem_re,
  input logic        busy,
  input logic        rd_op,
  input logic        done,
  input logic        start_mem,
  input logic        accept_addr,
  input logic        rd_sample
);

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  p_we_only_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && !rd_op));

  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));

  p_read_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_op) |-> mem_re);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_mem |=> reg_rdata[31]);

  p_addr_load_quick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_addr |=> !reg_rdata[31]);

  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !reg_rdata[31]);

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mem_addr));

  p_wdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_sample) |=> $stable(mem_wdata));

  p_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample |=> (reg_rdata[23:16] == $past(mem_rdata)));

endmodule

bind nvbyte_ctrl nvbyte_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rdata   (reg_rdata),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_rdata   (mem_rdata),
  .mem_we      (mem_we),
  .mem_re      (mem_re),
  .busy        (busy),
  .rd_op       (rd_op),
  .done        (done),
  .start_mem   (start_mem),
  .accept_addr (accept_addr),
  .rd_sample   (rd_sample)
);

// File: tb/test_nvbyte_ctrl.sv
module test_nvbyte_ctrl;

  localparam int W = 8;
  localparam int R = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        mem_we;
  logic        mem_re;

  int errors = 0;
  int checks = 0;
  bit done_flag = 0;
  bit cmp_en = 0;

  always #2 clk = ~clk;

  nvbyte_ctrl #(.WRITE_CYCLES(W), .READ_CYCLES(R)) i_nvbyte_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re)
  );

  // External memory model
  logic [7:0] mem [int];

  function automatic logic [7:0] mem_val(int a);
    if (mem.exists(a)) return mem[a];
    return 8'(a) ^ 8'hA5;
  endfunction

  assign mem_rdata = mem_val(int'(mem_addr));

  always @(posedge clk) if (mem_we) mem[int'(mem_addr)] = mem_wdata;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge
  int m_busy = 0, m_cnt = 0, m_rd = 0;
  int m_lo = 0, m_hi = 0, m_dat = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_rd = 0; m_lo = 0; m_hi = 0; m_dat = 0;
    end else if (m_busy != 0) begin
      if (m_cnt == (m_rd != 0 ? R : W) - 1) begin
        if (m_rd != 0) m_dat = int'(mem_val(m_hi * 256 + m_lo));
        m_busy = 0;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end else if (reg_wr && reg_wdata[31]) begin
      case (reg_wdata[30:29])
        2'd0: m_lo = int'(reg_wdata[23:16]);
        2'd1: m_hi = int'(reg_wdata[23:16]);
        2'd2: begin m_dat = int'(reg_wdata[23:16]); m_busy = 1; m_cnt = 0; m_rd = 0; end
        default: begin m_busy = 1; m_cnt = 0; m_rd = 1; end
      endcase
    end
  end

  // Per-clock comparison, away from the rising edge
  int busy_clks = 0, we_clks = 0, re_clks = 0;

  always @(negedge clk) begin
    if (cmp_en) begin
      bit e_we;
      e_we = (m_busy != 0) && (m_rd == 0) && (m_cnt >= W / 4) && (m_cnt < W / 4 + W / 2);
      chk(reg_rdata[31] == (m_busy != 0), "R9 busy bit", 32'(reg_rdata[31]), 32'(m_busy));
      chk(reg_rdata[23:16] == 8'(m_dat), "R8 byte field", 32'(reg_rdata[23:16]), 32'(m_dat));
      chk(reg_rdata[30:24] == 0 && reg_rdata[15:0] == 0, "R12 zero bits", reg_rdata, 32'(0));
      chk(mem_we == e_we, "R7 write strobe", 32'(mem_we), 32'(e_we));
      chk(mem_re == (m_busy != 0 && m_rd != 0), "R8 read strobe", 32'(mem_re), 32'(m_busy != 0 && m_rd != 0));
      chk(mem_addr == 16'(m_hi * 256 + m_lo), "R2 address", 32'(mem_addr), 32'(m_hi * 256 + m_lo));
      chk(mem_wdata == 8'(m_dat), "R3 write data", 32'(mem_wdata), 32'(m_dat));
      if (reg_rdata[31]) busy_clks++;
      if (mem_we) we_clks++;
      if (mem_re) re_clks++;
    end
  end

  task automatic host_cmd(logic [2:0] cmd, logic [7:0] b, logic [31:0] junk = '0);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = (junk & 32'h1F00_FFFF) | {cmd, 5'b0, b, 16'b0};
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!reg_rdata[31]) break;
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(reg_rdata == 0, "R11 reset register", reg_rdata, 0);
    chk(!mem_we && !mem_re, "R11 reset strobes", {mem_we, mem_re}, 0);
    chk(mem_addr == 0 && mem_wdata == 0, "R11 reset address/data", {mem_addr, mem_wdata}, 0);
    rst_n = 1'b1;
    cmp_en = 1;

    // R2 / R6 address loads
    host_cmd(3'b100, 8'h34);
    chk(!reg_rdata[31], "R6 low load no busy", 32'(reg_rdata[31]), 0);
    host_cmd(3'b101, 8'h12);
    chk(!reg_rdata[31], "R6 high load no busy", 32'(reg_rdata[31]), 0);
    chk(mem_addr == 16'h1234, "R2 composed address", 32'(mem_addr), 32'h1234);

    // R3 / R7 write cycle
    busy_clks = 0; we_clks = 0; re_clks = 0;
    host_cmd(3'b110, 8'hC3);
    wait_ready();
    chk(busy_clks == W, "R3 write busy length", busy_clks, W);
    chk(we_clks == W / 2, "R7 write strobe length", we_clks, W / 2);
    chk(re_clks == 0, "R7 no read strobe in write", re_clks, 0);
    chk(mem_val(32'h1234) == 8'hC3, "R3 byte stored", 32'(mem_val(32'h1234)), 32'hC3);

    // R4 / R8 read back
    mem[32'h1234] = 8'h6E;
    busy_clks = 0; re_clks = 0; we_clks = 0;
    host_cmd(3'b111, 8'h00);
    wait_ready();
    chk(busy_clks == R, "R4 read busy length", busy_clks, R);
    chk(re_clks == R, "R8 read strobe length", re_clks, R);
    chk(we_clks == 0, "R7 no write strobe in read", we_clks, 0);
    chk(reg_rdata[23:16] == 8'h6E, "R8 fetched byte", 32'(reg_rdata[23:16]), 32'h6E);

    // R5 inactive commands
    for (int c = 0; c < 4; c++) begin
      we_clks = 0; re_clks = 0; busy_clks = 0;
      host_cmd(3'(c), 8'hFF);
      repeat (2) @(negedge clk);
      chk(mem_addr == 16'h1234 && reg_rdata[23:16] == 8'h6E, "R5 inactive no change",
          {mem_addr, reg_rdata[23:16]}, {16'h1234, 8'h6E});
      chk(busy_clks == 0 && we_clks == 0 && re_clks == 0, "R5 inactive no cycle",
          busy_clks + we_clks + re_clks, 0);
    end

    // R8 read from unwritten location
    host_cmd(3'b100, 8'hCD);
    host_cmd(3'b101, 8'hAB);
    host_cmd(3'b111, 8'h00);
    wait_ready();
    chk(reg_rdata[23:16] == (8'hCD ^ 8'hA5), "R8 default byte", 32'(reg_rdata[23:16]), 32'(8'hCD ^ 8'hA5));

    // R10 commands during busy are ignored
    host_cmd(3'b100, 8'h10);
    host_cmd(3'b101, 8'h00);
    host_cmd(3'b110, 8'h77);
    host_cmd(3'b100, 8'h99);
    host_cmd(3'b110, 8'h11);
    host_cmd(3'b111, 8'h00);
    wait_ready();
    chk(mem_val(32'h0010) == 8'h77, "R10 write kept", 32'(mem_val(32'h0010)), 32'h77);
    chk(!mem.exists(32'h0099), "R10 no stray write", 32'(mem.exists(32'h0099)), 0);
    chk(mem_addr == 16'h0010, "R10 address kept", 32'(mem_addr), 32'h0010);
    chk(reg_rdata[23:16] == 8'h77, "R10 data kept", 32'(reg_rdata[23:16]), 32'h77);

    // R1 field positions with junk in other bits
    host_cmd(3'b100, 8'h5E, 32'hFFFF_FFFF);
    host_cmd(3'b101, 8'h21, 32'h1A00_BEEF);
    chk(mem_addr == 16'h215E, "R1 fields with junk", 32'(mem_addr), 32'h215E);
    host_cmd(3'b110, 8'h3C, 32'hFFFF_FFFF);
    wait_ready();
    chk(mem_val(32'h215E) == 8'h3C, "R1 write with junk", 32'(mem_val(32'h215E)), 32'h3C);

    // Back-to-back read right after ready
    host_cmd(3'b111, 8'h00);
    wait_ready();
    chk(reg_rdata[23:16] == 8'h3C, "R8 readback", 32'(reg_rdata[23:16]), 32'h3C);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule